// File: doc/BRIEF.md
# Step Attenuator Control Front End

This block turns the control pins of a 5-bit step attenuator into one registered attenuation word. Each LSB of the word is 1 dB and the full scale is 31 dB. A mode pin picks the source. One source is a serial port with data, serial clock and latch enable. The other is a five-wire parallel word. Both sources sit behind a single transparent output latch, and latch enable drives that latch in both modes.

All control pins are asynchronous to the system clock, so each one passes through a synchroniser of `SYNC_STAGES` flops. The serial clock is edge-detected in the system domain. When reset is released and the synchronisers have filled, the block loads a starting state once. Which state it loads depends on the mode pin and latch enable: the parallel word, or one of four fixed levels picked by two power-up select pins. A serial word whose trailing stop bit is 1 never reaches the output. It sets a sticky error flag.

Top module: `step_atten_ctrl`

## Requirements
- R1: While `rst_n` is low, `atten_out` is 0 and `stop_err` is 0.
- R2: `mode_serial` = 0 selects the parallel word as the latch source and 1 selects the serial shift register. In serial mode, `par_word` has no effect on `atten_out`.
- R3: The shift register moves one place only on a rising edge of `ser_clk`, taking `ser_data` as it stands at that edge. Changes on `ser_data` without a clock edge shift nothing.
- R4: A serial word is six bits. The first bit shifted in is the 16 dB bit, followed by the 8, 4, 2 and 1 dB bits, and the sixth bit is a stop bit that must be 0.
- R5: While `ser_le` is high the latch is transparent. While it is low, `atten_out` holds, whatever the serial or parallel inputs do.
- R6: In parallel mode with `ser_le` held high, a change on `par_word` reaches `atten_out` (bit 4 = 16 dB, bit 0 = 1 dB) without any other action.
- R7: In parallel mode, a high-then-low pulse on `ser_le` captures `par_word`. Changes on `par_word` before or after the pulse are not seen.
- R8: At start-up in serial mode, `atten_out` takes `par_word`, and the shift register is preset to that word with a 0 stop bit. Opening the latch before any shifting therefore keeps that value.
- R9: At start-up in parallel mode with `ser_le` low, `pup_sel` (bit 1 = second select pin, bit 0 = first) gives 00 = 0 dB, 01 = 8 dB, 10 = 16 dB and 11 = 31 dB.
- R10: At start-up in parallel mode with `ser_le` high, `pup_sel` is ignored and `atten_out` takes `par_word`.
- R11: If the latch opens in serial mode while the stop bit is 1, `stop_err` goes high and stays high until reset, and `atten_out` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| mode_serial | input | 1 | 0 = parallel source, 1 = serial source |
| ser_data | input | 1 | Serial data |
| ser_clk | input | 1 | Serial clock; data is taken on its rising edge |
| ser_le | input | 1 | Latch enable; the latch is transparent while high |
| par_word | input | 5 | Parallel attenuation word, bit 4 = 16 dB |
| pup_sel | input | 2 | Start-up level select for parallel mode |
| atten_out | output | 5 | Registered attenuation word, 1 dB per LSB |
| stop_err | output | 1 | Sticky flag for a serial word with a stop bit of 1 |

## Verification
On every cycle, the in-line assertions check the following: the latch holds while enable is low, the direct parallel path, the sticky error and the hold of the output on a bad stop bit, the shift only on a detected clock edge, and the start-up level table. Some behaviours involve a whole serial word or the pin settings present during reset. Only the directed scenarios can show these: the MSB-first bit weights, the preset of the stop bit at serial start-up, the masking of the parallel word in serial mode, and the precedence of latch enable over the power-up pins.

// File: rtl/satt_pkg.sv
`timescale 1ns/1ps
package satt_pkg;

   typedef enum logic {
      SRC_PARALLEL = 1'b0,
      SRC_SERIAL   = 1'b1
   } src_mode_e;

   // start-up level picked by the two select pins, for a word of 'bits' width
   function automatic int unsigned pup_level(input logic [1:0] sel, input int unsigned bits);
      int unsigned lvl;
      case (sel)
         2'b00:   lvl = 0;
         2'b01:   lvl = 1 << (bits - 2);
         2'b10:   lvl = 1 << (bits - 1);
         default: lvl = (1 << bits) - 1;
      endcase
      return lvl;
   endfunction

endpackage

// File: rtl/satt_sync.sv
`timescale 1ns/1ps
module satt_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] async_in,
   output logic [W-1:0] sync_out
);

   if (STAGES < 2) begin : g_bad_depth
      $error("satt_sync needs at least two stages");
   end

   logic [W-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[0] <= '0;
            else        stg[0] <= async_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   assign sync_out = stg[STAGES-1];

endmodule

// File: rtl/satt_shift.sv
`timescale 1ns/1ps
module satt_shift #(
   parameter int ATT_BITS = 5,
   localparam int SH_W    = ATT_BITS + 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            sclk_s,
   input  logic            sdata_s,
   input  logic            load,
   input  logic [SH_W-1:0] load_word,
   output logic [SH_W-1:0] word
);

   logic sclk_prev;
   logic sclk_rise;

   assign sclk_rise = sclk_s & ~sclk_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_prev <= 1'b0;
         word      <= '0;
      end else begin
         sclk_prev <= sclk_s;
         if (load)           word <= load_word;
         else if (sclk_rise) word <= {word[SH_W-2:0], sdata_s};
      end
   end

   // R3: no movement without a detected serial clock edge
   a_r3_shift_only_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !sclk_rise) |=> $stable(word));

   // R3: the new LSB is the data seen at the edge
   a_r3_shift_takes_data: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && sclk_rise) |=> (word[0] == $past(sdata_s)));

endmodule

// File: rtl/satt_latch.sv
`timescale 1ns/1ps
module satt_latch
   import satt_pkg::*;
#(
   parameter int ATT_BITS    = 5,
   parameter int SYNC_STAGES = 2,
   localparam int SH_W       = ATT_BITS + 1,
   localparam int CNT_W      = $clog2(SYNC_STAGES + 1),
   localparam logic [CNT_W-1:0] LOAD_AT = CNT_W'(SYNC_STAGES)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  src_mode_e           mode,
   input  logic                le,
   input  logic [ATT_BITS-1:0] par,
   input  logic [1:0]          pup,
   input  logic [SH_W-1:0]     sh_word,
   output logic                load,
   output logic [ATT_BITS-1:0] atten,
   output logic                err
);

   logic [CNT_W-1:0]    cnt;
   logic                done;
   logic [ATT_BITS-1:0] init_val;

   assign load = !done && (cnt == LOAD_AT);

   always_comb begin
      if (mode == SRC_SERIAL || le) init_val = par;
      else                          init_val = ATT_BITS'(pup_level(pup, ATT_BITS));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         done  <= 1'b0;
         atten <= '0;
         err   <= 1'b0;
      end else if (!done) begin
         if (load) begin
            done  <= 1'b1;
            atten <= init_val;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end else if (le) begin
         if (mode == SRC_SERIAL) begin
            if (sh_word[0]) err   <= 1'b1;
            else            atten <= sh_word[SH_W-1:1];
         end else begin
            atten <= par;
         end
      end
   end

   // R5: closed latch holds
   a_r5_hold_when_closed: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !le) |=> $stable(atten));

   // R6: direct parallel path
   a_r6_direct_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (done && le && mode == SRC_PARALLEL) |=> (atten == $past(par)));

   // R11: error is sticky
   a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);

   // R11: bad stop bit leaves the output alone and flags
   a_r11_bad_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (done && le && mode == SRC_SERIAL && sh_word[0]) |=> ($stable(atten) && err));

   // R9: start-up levels at the table ends
   a_r9_pup_top: assert property (@(posedge clk) disable iff (!rst_n)
      (load && mode == SRC_PARALLEL && !le && pup == 2'b11) |=> (&atten));
   a_r9_pup_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (load && mode == SRC_PARALLEL && !le && pup == 2'b00) |=> (atten == '0));

endmodule

// File: rtl/step_atten_ctrl.sv
`timescale 1ns/1ps
module step_atten_ctrl
   import satt_pkg::*;
#(
   parameter int ATT_BITS    = 5,
   parameter int SYNC_STAGES = 2,
   localparam int SH_W       = ATT_BITS + 1,
   localparam int SYNC_W     = ATT_BITS + 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                mode_serial,
   input  logic                ser_data,
   input  logic                ser_clk,
   input  logic                ser_le,
   input  logic [ATT_BITS-1:0] par_word,
   input  logic [1:0]          pup_sel,
   output logic [ATT_BITS-1:0] atten_out,
   output logic                stop_err
);

   if (ATT_BITS < 3) begin : g_bad_bits
      $error("step_atten_ctrl needs ATT_BITS of at least 3");
   end

   logic [SYNC_W-1:0]   s_vec;
   logic                s_mode, s_data, s_clk, s_le;
   logic [1:0]          s_pup;
   logic [ATT_BITS-1:0] s_par;
   logic                load;
   logic [SH_W-1:0]     sh_word;

   satt_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in ({mode_serial, ser_data, ser_clk, ser_le, pup_sel, par_word}),
      .sync_out (s_vec)
   );

   assign {s_mode, s_data, s_clk, s_le, s_pup, s_par} = s_vec;

   satt_shift #(.ATT_BITS(ATT_BITS)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .sclk_s    (s_clk),
      .sdata_s   (s_data),
      .load      (load),
      .load_word ({s_par, 1'b0}),
      .word      (sh_word)
   );

   satt_latch #(.ATT_BITS(ATT_BITS), .SYNC_STAGES(SYNC_STAGES)) u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode    (src_mode_e'(s_mode)),
      .le      (s_le),
      .par     (s_par),
      .pup     (s_pup),
      .sh_word (sh_word),
      .load    (load),
      .atten   (atten_out),
      .err     (stop_err)
   );

endmodule

// File: tb/step_atten_ctrl_tb.sv
`timescale 1ns/1ps
module step_atten_ctrl_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode_serial = 1'b0;
   logic       ser_data = 1'b0;
   logic       ser_clk = 1'b0;
   logic       ser_le = 1'b0;
   logic [4:0] par_word = '0;
   logic [1:0] pup_sel = '0;
   logic [4:0] atten_out;
   logic       stop_err;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   step_atten_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .mode_serial(mode_serial), .ser_data(ser_data),
      .ser_clk(ser_clk), .ser_le(ser_le), .par_word(par_word), .pup_sel(pup_sel),
      .atten_out(atten_out), .stop_err(stop_err)
   );

   task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic power_up(input logic m, input logic le, input logic [4:0] p, input logic [1:0] pu);
      @(negedge clk);
      rst_n = 1'b0;
      mode_serial = m; ser_le = le; par_word = p; pup_sel = pu;
      ser_clk = 1'b0; ser_data = 1'b0;
      wait_cyc(3);
      chk("R1 atten in reset", atten_out, 5'd0);
      chk("R1 err in reset", {4'd0, stop_err}, 5'd0);
      rst_n = 1'b1;
      wait_cyc(8);
   endtask

   task automatic send_bit(input logic b);
      ser_data = b;
      wait_cyc(3);
      ser_clk = 1'b1;
      wait_cyc(3);
      ser_clk = 1'b0;
      wait_cyc(3);
   endtask

   task automatic send_word(input logic [4:0] v, input logic stop);
      for (int i = 4; i >= 0; i--) send_bit(v[i]);
      send_bit(stop);
   endtask

   task automatic pulse_le();
      ser_le = 1'b1;
      wait_cyc(6);
      ser_le = 1'b0;
      wait_cyc(6);
   endtask

   task automatic t_pup_table();
      logic [4:0] lv [4] = '{5'd0, 5'd8, 5'd16, 5'd31};
      for (int k = 0; k < 4; k++) begin
         power_up(1'b0, 1'b0, 5'd5, 2'(k));
         chk("R9 start-up level", atten_out, lv[k]);
      end
   endtask

   task automatic t_direct();
      power_up(1'b0, 1'b1, 5'd13, 2'b11);
      chk("R10 le high ignores pup", atten_out, 5'd13);
      par_word = 5'd21; wait_cyc(6);
      chk("R6 direct follows", atten_out, 5'd21);
      par_word = 5'd3; wait_cyc(6);
      chk("R6 direct follows again", atten_out, 5'd3);
   endtask

   task automatic t_latched();
      power_up(1'b0, 1'b0, 5'd0, 2'b00);
      par_word = 5'd9; wait_cyc(6);
      chk("R7 change while closed ignored", atten_out, 5'd0);
      pulse_le();
      chk("R7 pulse captures", atten_out, 5'd9);
      par_word = 5'd22; wait_cyc(6);
      chk("R7 change after pulse ignored", atten_out, 5'd9);
   endtask

   task automatic t_serial();
      power_up(1'b1, 1'b0, 5'd19, 2'b10);
      chk("R8 serial start-up from parallel word", atten_out, 5'd19);
      pulse_le();
      chk("R8 preset stop bit keeps value", atten_out, 5'd19);
      chk("R8 no error from preset", {4'd0, stop_err}, 5'd0);
      send_word(5'b10110, 1'b0);
      chk("R5 shift while closed holds", atten_out, 5'd19);
      pulse_le();
      chk("R4 word 10110", atten_out, 5'd22);
      send_word(5'b10000, 1'b0); pulse_le();
      chk("R4 first bit is 16 dB", atten_out, 5'd16);
      send_word(5'b00001, 1'b0); pulse_le();
      chk("R4 fifth bit is 1 dB", atten_out, 5'd1);
      ser_le = 1'b1; par_word = 5'd5; wait_cyc(6);
      chk("R2 parallel word masked in serial", atten_out, 5'd1);
      ser_le = 1'b0; wait_cyc(4);
      for (int i = 0; i < 4; i++) begin ser_data = ~ser_data; wait_cyc(3); end
      ser_data = 1'b0; wait_cyc(3);
      pulse_le();
      chk("R3 data without clock edge", atten_out, 5'd1);
   endtask

   task automatic t_stop_err();
      send_word(5'b00101, 1'b1); pulse_le();
      chk("R11 bad stop holds output", atten_out, 5'd1);
      chk("R11 error flagged", {4'd0, stop_err}, 5'd1);
      send_word(5'b01100, 1'b0); pulse_le();
      chk("R11 good word after error", atten_out, 5'd12);
      chk("R11 error sticky", {4'd0, stop_err}, 5'd1);
      power_up(1'b1, 1'b0, 5'd7, 2'b00);
      chk("R1 reset clears error", {4'd0, stop_err}, 5'd0);
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   initial begin
      t_pup_table();
      t_direct();
      t_latched();
      t_serial();
      t_stop_err();
      summary();
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      summary();
      $finish;
   end

endmodule